// File: doc/BRIEF.md
# Interrupt Entry and Stack Sequencer

This block handles all stack and vector traffic of a small 8-bit processor core. The traffic covers power-up reset, the software break instruction, maskable and non-maskable hardware interrupts, subroutine call and return, and return from interrupt. It holds the 8-bit stack pointer and drives a byte-wide memory port with a combinational read path. The execution core keeps the program counter and the status flags. The core presents both at an instruction-boundary strobe and takes back the updated program counter and flag byte when the block reports that a sequence has finished.

Hardware requests may arrive at any time and are held until the core is at an instruction boundary. Software operations are chosen by a 3-bit code that is sampled with the strobe. While a sequence runs, the block reports busy, and it ignores any further strobe. When a sequence finishes, the block delivers its results as one-cycle load pulses.

Top module: `trap_stack_seq`

## Requirements
- R1: After reset is released, `busy` stays high for 8 cycles. In those cycles the block reads the reset vector from 0xFFFC (low byte) and 0xFFFD (high byte). In the first cycle with `busy` low, it then pulses `pc_load`, `flags_load` and `regs_clear`, with `pc_out` equal to the vector, `flags_out` equal to 0x24 and `sp_out` equal to 0xFD.
- R2: A push writes to address 0x0100 OR SP and then decrements SP. A pop increments SP and then reads from 0x0100 OR SP. SP wraps modulo 256 in both directions.
- R3: A flag byte written to the stack is laid out as bit7 N, bit6 V, bit5 constant 1, bit4 break, bit3 D, bit2 I, bit1 Z, bit0 C. Bit 5 is always 1 in every pushed byte and in every `flags_out` value that is loaded.
- R4: Op code 1 (software break) pushes the high byte and then the low byte of `pc_in`+2, followed by the flag byte with break=1. It then loads `pc_out` from the word at 0xFFFE/0xFFFF and `flags_out` from `flags_in` with I=1 and every other bit unchanged, D included.
- R5: An accepted maskable interrupt pushes `pc_in` unchanged (high byte, then low byte) and then the flag byte with break=0. It uses the vector at 0xFFFE/0xFFFF and loads `flags_out` with I=1.
- R6: A non-maskable interrupt pushes the same frame as R5 but uses the vector at 0xFFFA/0xFFFB. It is accepted even when I=1, and it takes precedence over a pending maskable request and over any software op code presented at the same strobe.
- R7: A pending maskable request is discarded at the next accepted strobe if `flags_in` bit 2 (I) is 1 at that strobe, or if a non-maskable request wins that strobe.
- R8: Op code 2 (call) pushes the high byte and then the low byte of `pc_in`+2, and then loads `pc_out` with `call_target`.
- R9: Op code 3 (return) pops the low byte and then the high byte, and loads `pc_out` with the popped word plus 1.
- R10: Op code 4 (return from interrupt) pops the flag byte first and then the low and high program-counter bytes. It loads `pc_out` with the popped word and `flags_out` with the popped byte with bits 4 and 5 forced to 1.
- R11: Op code 5 (push status) writes one flag byte with break=1 and decrements SP, and pulses neither `pc_load` nor `flags_load`.
- R12: While `busy` is high, strobes and op codes are ignored. A hardware request that arrives while busy is held and is serviced at the first strobe after `busy` falls.
- R13: `pc_load` and `flags_load` are single-cycle pulses. They occur only in the first cycle after the last memory access of a sequence, which is the first cycle with `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; releasing it starts the reset sequence |
| boundary | input | 1 | Instruction-boundary strobe |
| op_sel | input | 3 | Software operation code sampled with the strobe (0 none, 1 break, 2 call, 3 return, 4 return from interrupt, 5 push status) |
| nmi_req | input | 1 | Non-maskable interrupt request pulse |
| irq_req | input | 1 | Maskable interrupt request pulse |
| pc_in | input | 16 | Address of the instruction at the boundary |
| flags_in | input | 8 | Current flag byte |
| call_target | input | 16 | Destination of a call |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 8 | Memory read data, valid in the same cycle |
| busy | output | 1 | A sequence is in progress |
| pc_out | output | 16 | New program counter |
| pc_load | output | 1 | Pulse: core takes `pc_out` |
| flags_out | output | 8 | New flag byte |
| flags_load | output | 1 | Pulse: core takes `flags_out` |
| regs_clear | output | 1 | Pulse at the end of reset: core clears its data registers |
| sp_out | output | 8 | Current stack pointer |

## Verification
The hardest situations to reach are those where a request and the strobe compete with a running sequence. In one, a non-maskable pulse lands while a call is still pushing and a return op is presented in the same cycle. That request must survive the ignored strobe and then win over the return op at the next boundary. The bench reaches this by timing the pulses to the falling clock edge inside the call's two busy cycles. Stack wrap is reached without hundreds of pushes. The bench preloads its own stack memory, pops across 0xFF into page offset 0x00, and then pushes back across the same boundary.

// File: rtl/tss_pkg.sv
package tss_pkg;

   // bit positions inside the flag byte that the sequencer itself touches
   localparam int FB_I   = 2;
   localparam int FB_B   = 4;
   localparam int FB_ONE = 5;

   // software operation codes presented with the boundary strobe
   localparam logic [2:0] OP_NONE  = 3'd0;
   localparam logic [2:0] OP_BRK   = 3'd1;
   localparam logic [2:0] OP_CALL  = 3'd2;
   localparam logic [2:0] OP_RET   = 3'd3;
   localparam logic [2:0] OP_RETI  = 3'd4;
   localparam logic [2:0] OP_PUSHF = 3'd5;

   typedef enum logic [2:0] {
      K_RESET = 3'd0,
      K_BRK   = 3'd1,
      K_IRQ   = 3'd2,
      K_NMI   = 3'd3,
      K_CALL  = 3'd4,
      K_RET   = 3'd5,
      K_RETI  = 3'd6,
      K_PUSHF = 3'd7
   } seq_kind_t;

endpackage

// File: rtl/tss_req_arb.sv
module tss_req_arb
   import tss_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      strobe,
   input  logic      nmi_req,
   input  logic      irq_req,
   input  logic      irq_mask,
   input  logic [2:0] op_sel,
   output logic      start,
   output seq_kind_t kind
);

   logic nmi_p, irq_p;
   logic take_nmi, take_irq, take_sw, sw_valid;

   always_comb begin
      sw_valid = (op_sel == OP_BRK) || (op_sel == OP_CALL) || (op_sel == OP_RET) ||
                 (op_sel == OP_RETI) || (op_sel == OP_PUSHF);
      take_nmi = strobe && nmi_p;
      take_irq = strobe && !nmi_p && irq_p && !irq_mask;
      take_sw  = strobe && !nmi_p && !take_irq && sw_valid;
      start    = take_nmi || take_irq || take_sw;
      if (take_nmi)      kind = K_NMI;
      else if (take_irq) kind = K_IRQ;
      else begin
         case (op_sel)
            OP_BRK:   kind = K_BRK;
            OP_CALL:  kind = K_CALL;
            OP_RET:   kind = K_RET;
            OP_RETI:  kind = K_RETI;
            OP_PUSHF: kind = K_PUSHF;
            default:  kind = K_RESET;
         endcase
      end
   end

   // pending requests: set by pulses, consumed at an honoured strobe
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nmi_p <= 1'b0;
         irq_p <= 1'b0;
      end else begin
         nmi_p <= (nmi_p && !take_nmi) || nmi_req;
         irq_p <= (irq_p && !strobe) || irq_req;
      end
   end

   // R6: at most one source wins a strobe
   p_single_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({take_nmi, take_irq, take_sw}));

   // R7: a maskable grant never happens with the mask set
   p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      take_irq |-> !irq_mask);

   // R12: a held non-maskable request survives cycles without a strobe
   p_nmi_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (nmi_p && !strobe) |=> nmi_p);

endmodule

// File: rtl/tss_sp_unit.sv
module tss_sp_unit #(
   parameter int ADDR_W     = 16,
   parameter int SP_W       = 8,
   parameter int STACK_PAGE = 1,
   parameter int SP_RESET   = 'hFD
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              do_push,
   input  logic              do_pop,
   output logic [SP_W-1:0]   sp,
   output logic [ADDR_W-1:0] push_addr,
   output logic [ADDR_W-1:0] pop_addr
);

   localparam int PAGE_W = ADDR_W - SP_W;

   logic [SP_W-1:0] sp_q, sp_inc, sp_dec;

   assign sp_inc = sp_q + SP_W'(1);
   assign sp_dec = sp_q - SP_W'(1);
   assign sp     = sp_q;

   generate
      if (PAGE_W > 0) begin : g_paged
         localparam logic [PAGE_W-1:0] PAGE = PAGE_W'(STACK_PAGE);
         assign push_addr = {PAGE, sp_q};
         assign pop_addr  = {PAGE, sp_inc};
      end else begin : g_bad_page
         $error("stack pointer must be narrower than the address bus");
         assign push_addr = '0;
         assign pop_addr  = '0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sp_q <= SP_W'(SP_RESET);
      else if (do_push) sp_q <= sp_dec;
      else if (do_pop)  sp_q <= sp_inc;
   end

   // R2: write first, then decrement
   p_push_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
      do_push |=> sp_q == SP_W'($past(sp_q) - SP_W'(1)));

   // R2: increment, then read
   p_pop_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
      do_pop |=> sp_q == SP_W'($past(sp_q) + SP_W'(1)));

   p_no_push_pop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(do_push && do_pop));

endmodule

// File: rtl/tss_flag_codec.sv
module tss_flag_codec
   import tss_pkg::*;
#(
   parameter int DATA_W = 8
)(
   input  logic [DATA_W-1:0] live_flags,
   input  logic              brk_bit,
   input  logic [DATA_W-1:0] popped,
   output logic [DATA_W-1:0] push_byte,
   output logic [DATA_W-1:0] restored,
   output logic [DATA_W-1:0] entry_flags
);

   localparam logic [DATA_W-1:0] M_ONE = DATA_W'(1) << FB_ONE;
   localparam logic [DATA_W-1:0] M_B   = DATA_W'(1) << FB_B;
   localparam logic [DATA_W-1:0] M_I   = DATA_W'(1) << FB_I;

   always_comb begin
      push_byte        = live_flags | M_ONE;
      push_byte[FB_B]  = brk_bit;
      restored         = popped | M_ONE | M_B;
      entry_flags      = live_flags | M_ONE | M_I;
   end

   // R3: the constant bit always reaches the stack and the core
   always_comb begin
      a_push_one_r3: assert (push_byte[FB_ONE] == 1'b1);
      a_restore_one_r3: assert (restored[FB_ONE] && restored[FB_B]);
   end

endmodule

// File: rtl/trap_stack_seq.sv
module trap_stack_seq
   import tss_pkg::*;
#(
   parameter int ADDR_W       = 16,
   parameter int DATA_W       = 8,
   parameter int SP_W         = 8,
   parameter int STACK_PAGE   = 1,
   parameter int SP_RESET     = 'hFD,
   parameter int VEC_NMI      = 'hFFFA,
   parameter int VEC_RST      = 'hFFFC,
   parameter int VEC_IRQ      = 'hFFFE,
   parameter int RESET_CYCLES = 8,
   parameter int BRK_SKIP     = 2,
   parameter int CALL_SKIP    = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              boundary,
   input  logic [2:0]        op_sel,
   input  logic              nmi_req,
   input  logic              irq_req,
   input  logic [ADDR_W-1:0] pc_in,
   input  logic [DATA_W-1:0] flags_in,
   input  logic [ADDR_W-1:0] call_target,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_we,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              busy,
   output logic [ADDR_W-1:0] pc_out,
   output logic              pc_load,
   output logic [DATA_W-1:0] flags_out,
   output logic              flags_load,
   output logic              regs_clear,
   output logic [SP_W-1:0]   sp_out
);

   localparam int STEP_W = $clog2(RESET_CYCLES + 1);
   localparam logic [STEP_W-1:0] RST_RD_LO = STEP_W'(RESET_CYCLES - 2);
   localparam logic [STEP_W-1:0] RST_RD_HI = STEP_W'(RESET_CYCLES - 1);
   localparam logic [DATA_W-1:0] RESET_FLAGS = DATA_W'((1 << FB_ONE) | (1 << FB_I));

   generate
      if (DATA_W != 8) begin : g_chk_data
         $error("byte-wide memory port required");
      end
      if (ADDR_W != 2 * DATA_W) begin : g_chk_addr
         $error("address must be two data bytes wide");
      end
      if (SP_W != DATA_W) begin : g_chk_sp
         $error("stack pointer must be one data byte wide");
      end
      if (RESET_CYCLES < 3) begin : g_chk_rst
         $error("reset sequence needs at least three cycles");
      end
   endgenerate

   seq_kind_t         kind_q, arb_kind;
   logic [STEP_W-1:0] step_q;
   logic              active_q, arb_start, strobe;
   logic [ADDR_W-1:0] pc_q, tgt_q;
   logic [DATA_W-1:0] flg_q, lo_q, popf_q;

   logic              acc_we, sp_push, sp_pop, last;
   logic [ADDR_W-1:0] acc_addr, ret_addr, vec_base, rd_word;
   logic [DATA_W-1:0] acc_wdata, push_byte, restored, entry_flags;
   logic              brk_bit;
   logic [ADDR_W-1:0] push_addr, pop_addr;

   assign strobe = boundary && !active_q;

   tss_req_arb u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe   (strobe),
      .nmi_req  (nmi_req),
      .irq_req  (irq_req),
      .irq_mask (flags_in[FB_I]),
      .op_sel   (op_sel),
      .start    (arb_start),
      .kind     (arb_kind)
   );

   tss_sp_unit #(
      .ADDR_W     (ADDR_W),
      .SP_W       (SP_W),
      .STACK_PAGE (STACK_PAGE),
      .SP_RESET   (SP_RESET)
   ) u_sp (
      .clk       (clk),
      .rst_n     (rst_n),
      .do_push   (sp_push),
      .do_pop    (sp_pop),
      .sp        (sp_out),
      .push_addr (push_addr),
      .pop_addr  (pop_addr)
   );

   tss_flag_codec #(.DATA_W(DATA_W)) u_codec (
      .live_flags  (flg_q),
      .brk_bit     (brk_bit),
      .popped      (popf_q),
      .push_byte   (push_byte),
      .restored    (restored),
      .entry_flags (entry_flags)
   );

   // sequence-dependent operands
   always_comb begin
      brk_bit  = (kind_q != K_IRQ) && (kind_q != K_NMI);
      rd_word  = {mem_rdata, lo_q};
      case (kind_q)
         K_BRK:   ret_addr = pc_q + ADDR_W'(BRK_SKIP);
         K_CALL:  ret_addr = pc_q + ADDR_W'(CALL_SKIP);
         default: ret_addr = pc_q;
      endcase
      case (kind_q)
         K_NMI:   vec_base = ADDR_W'(VEC_NMI);
         K_RESET: vec_base = ADDR_W'(VEC_RST);
         default: vec_base = ADDR_W'(VEC_IRQ);
      endcase
   end

   // per-step memory access
   always_comb begin
      acc_we    = 1'b0;
      acc_addr  = '0;
      acc_wdata = '0;
      sp_push   = 1'b0;
      sp_pop    = 1'b0;
      last      = 1'b0;
      if (active_q) begin
         case (kind_q)
            K_RESET: begin
               if (step_q == RST_RD_LO) begin
                  acc_addr = vec_base;
               end else if (step_q == RST_RD_HI) begin
                  acc_addr = vec_base + ADDR_W'(1);
                  last     = 1'b1;
               end
            end
            K_BRK, K_IRQ, K_NMI: begin
               case (step_q)
                  STEP_W'(0): begin
                     sp_push = 1'b1; acc_we = 1'b1; acc_addr = push_addr;
                     acc_wdata = ret_addr[ADDR_W-1:DATA_W];
                  end
                  STEP_W'(1): begin
                     sp_push = 1'b1; acc_we = 1'b1; acc_addr = push_addr;
                     acc_wdata = ret_addr[DATA_W-1:0];
                  end
                  STEP_W'(2): begin
                     sp_push = 1'b1; acc_we = 1'b1; acc_addr = push_addr;
                     acc_wdata = push_byte;
                  end
                  STEP_W'(3): acc_addr = vec_base;
                  STEP_W'(4): begin
                     acc_addr = vec_base + ADDR_W'(1);
                     last     = 1'b1;
                  end
                  default: ;
               endcase
            end
            K_CALL: begin
               sp_push = 1'b1; acc_we = 1'b1; acc_addr = push_addr;
               if (step_q == STEP_W'(0)) begin
                  acc_wdata = ret_addr[ADDR_W-1:DATA_W];
               end else begin
                  acc_wdata = ret_addr[DATA_W-1:0];
                  last      = 1'b1;
               end
            end
            K_RET: begin
               sp_pop   = 1'b1;
               acc_addr = pop_addr;
               last     = (step_q == STEP_W'(1));
            end
            K_RETI: begin
               sp_pop   = 1'b1;
               acc_addr = pop_addr;
               last     = (step_q == STEP_W'(2));
            end
            K_PUSHF: begin
               sp_push = 1'b1; acc_we = 1'b1; acc_addr = push_addr;
               acc_wdata = push_byte;
               last      = 1'b1;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q     <= K_RESET;
         step_q     <= '0;
         active_q   <= 1'b1;
         pc_q       <= '0;
         tgt_q      <= '0;
         flg_q      <= '0;
         lo_q       <= '0;
         popf_q     <= '0;
         pc_out     <= '0;
         flags_out  <= RESET_FLAGS;
         pc_load    <= 1'b0;
         flags_load <= 1'b0;
         regs_clear <= 1'b0;
      end else begin
         pc_load    <= 1'b0;
         flags_load <= 1'b0;
         regs_clear <= 1'b0;
         if (!active_q) begin
            if (arb_start) begin
               kind_q   <= arb_kind;
               step_q   <= '0;
               active_q <= 1'b1;
               pc_q     <= pc_in;
               tgt_q    <= call_target;
               flg_q    <= flags_in;
            end
         end else begin
            lo_q <= mem_rdata;
            if (kind_q == K_RETI && step_q == STEP_W'(0)) popf_q <= mem_rdata;
            if (last) begin
               active_q <= 1'b0;
               case (kind_q)
                  K_RESET: begin
                     pc_out     <= rd_word;
                     flags_out  <= RESET_FLAGS;
                     pc_load    <= 1'b1;
                     flags_load <= 1'b1;
                     regs_clear <= 1'b1;
                  end
                  K_BRK, K_IRQ, K_NMI: begin
                     pc_out     <= rd_word;
                     flags_out  <= entry_flags;
                     pc_load    <= 1'b1;
                     flags_load <= 1'b1;
                  end
                  K_CALL: begin
                     pc_out  <= tgt_q;
                     pc_load <= 1'b1;
                  end
                  K_RET: begin
                     pc_out  <= rd_word + ADDR_W'(1);
                     pc_load <= 1'b1;
                  end
                  K_RETI: begin
                     pc_out     <= rd_word;
                     flags_out  <= restored;
                     pc_load    <= 1'b1;
                     flags_load <= 1'b1;
                  end
                  default: ;
               endcase
            end else begin
               step_q <= step_q + STEP_W'(1);
            end
         end
      end
   end

   assign mem_addr  = acc_addr;
   assign mem_wdata = acc_wdata;
   assign mem_we    = acc_we;
   assign busy      = active_q;

   // R13: result pulses only as busy drops
   p_load_at_end_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_load || flags_load) |-> $fell(busy));

   // R2: every write targets the stack page
   p_we_stack_page_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_addr[ADDR_W-1:SP_W] == (ADDR_W-SP_W)'(STACK_PAGE));

   // R12: a sequence starts only from an idle strobe
   p_start_from_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(boundary));

   // R3: loaded flags keep the constant bit
   p_flags_bit5_r3: assert property (@(posedge clk) disable iff (!rst_n)
      flags_load |-> flags_out[FB_ONE]);

   // R11: push status loads nothing
   p_pushf_no_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && last && kind_q == K_PUSHF) |=> (!pc_load && !flags_load));

endmodule

// File: tb/sim_trap_stack_seq.sv
module sim_trap_stack_seq;
   localparam int CLK_PERIOD = 10;

   logic        clk, rst_n, boundary, nmi_req, irq_req;
   logic [2:0]  op_sel;
   logic [15:0] pc_in, call_target, mem_addr, pc_out;
   logic [7:0]  flags_in, mem_wdata, mem_rdata, flags_out, sp_out;
   logic        mem_we, busy, pc_load, flags_load, regs_clear;

   int checks = 0;
   int failures = 0;

   logic [7:0]  stk [256];
   logic [7:0]  vecm [6];
   int          wr_cnt = 0;
   logic [15:0] wr_a [16];
   logic [7:0]  wr_d [16];

   trap_stack_seq u0 (
      .clk(clk), .rst_n(rst_n), .boundary(boundary), .op_sel(op_sel),
      .nmi_req(nmi_req), .irq_req(irq_req), .pc_in(pc_in), .flags_in(flags_in),
      .call_target(call_target), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_we(mem_we), .mem_rdata(mem_rdata), .busy(busy), .pc_out(pc_out),
      .pc_load(pc_load), .flags_out(flags_out), .flags_load(flags_load),
      .regs_clear(regs_clear), .sp_out(sp_out)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   always_comb begin
      if (mem_addr[15:8] == 8'h01)      mem_rdata = stk[mem_addr[7:0]];
      else if (mem_addr >= 16'hFFFA)    mem_rdata = vecm[int'(mem_addr - 16'hFFFA)];
      else                              mem_rdata = 8'h00;
   end

   always @(posedge clk) begin
      if (rst_n && mem_we) begin
         if (mem_addr[15:8] == 8'h01) stk[mem_addr[7:0]] <= mem_wdata;
         wr_a[wr_cnt % 16] <= mem_addr;
         wr_d[wr_cnt % 16] <= mem_wdata;
         wr_cnt <= wr_cnt + 1;
      end
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic check_wr(input string req, input int idx, input int addr, input int data);
      check(req, "write address", int'(wr_a[idx % 16]), addr);
      check(req, "write data", int'(wr_d[idx % 16]), data);
   endtask

   task automatic drive_bnd(input logic [2:0] op, input logic [15:0] pc,
                            input logic [7:0] flg, input logic [15:0] tgt);
      @(negedge clk);
      boundary = 1'b1; op_sel = op; pc_in = pc; flags_in = flg; call_target = tgt;
      @(negedge clk);
      boundary = 1'b0; op_sel = 3'd0;
   endtask

   task automatic wait_done();
      for (int n = 0; n < 100 && busy; n++) @(negedge clk);
   endtask

   task automatic pulse_req(input logic nmi, input logic irq);
      @(negedge clk);
      nmi_req = nmi; irq_req = irq;
      @(negedge clk);
      nmi_req = 1'b0; irq_req = 1'b0;
   endtask

   task automatic t_reset();
      int n = 0;
      rst_n = 1'b1;
      while (busy && n < 50) begin n++; @(negedge clk); end
      check("R1", "reset busy cycles", n, 8);
      check("R1", "pc_load", int'(pc_load), 1);
      check("R1", "regs_clear", int'(regs_clear), 1);
      check("R1", "reset vector", int'(pc_out), 'h1234);
      check("R1", "reset flags", int'(flags_out), 'h24);
      check("R1", "reset sp", int'(sp_out), 'hFD);
      @(negedge clk);
      check("R13", "pc_load single pulse", int'(pc_load), 0);
   endtask

   task automatic t_call();
      int b = wr_cnt;
      drive_bnd(3'd2, 16'h2000, 8'h00, 16'h3456);
      wait_done();
      check("R8", "writes", wr_cnt - b, 2);
      check_wr("R8", b, 'h01FD, 'h20);
      check_wr("R8", b + 1, 'h01FC, 'h02);
      check("R8", "pc_out", int'(pc_out), 'h3456);
      check("R13", "pc_load at end", int'(pc_load), 1);
      check("R13", "flags_load absent", int'(flags_load), 0);
      check("R2", "sp after call", int'(sp_out), 'hFB);
   endtask

   task automatic t_ret(input logic [15:0] exp_pc, input logic [7:0] exp_sp, input string req);
      drive_bnd(3'd3, 16'h0000, 8'h00, 16'h0000);
      wait_done();
      check(req, "return pc", int'(pc_out), int'(exp_pc));
      check(req, "return sp", int'(sp_out), int'(exp_sp));
      check("R13", "pc_load at end", int'(pc_load), 1);
   endtask

   task automatic t_brk();
      int b = wr_cnt;
      drive_bnd(3'd1, 16'h4000, 8'h09, 16'h0000);
      wait_done();
      check("R4", "writes", wr_cnt - b, 3);
      check_wr("R4", b, 'h01FD, 'h40);
      check_wr("R4", b + 1, 'h01FC, 'h02);
      check_wr("R3", b + 2, 'h01FB, 'h39);
      check("R4", "vector", int'(pc_out), 'h9000);
      check("R4", "flags I set D kept", int'(flags_out), 'h2D);
      check("R4", "flags_load", int'(flags_load), 1);
   endtask

   task automatic t_reti(input logic [7:0] exp_f, input logic [15:0] exp_pc, input logic [7:0] exp_sp);
      drive_bnd(3'd4, 16'h0000, 8'h04, 16'h0000);
      wait_done();
      check("R10", "restored flags", int'(flags_out), int'(exp_f));
      check("R10", "restored pc", int'(pc_out), int'(exp_pc));
      check("R10", "sp", int'(sp_out), int'(exp_sp));
      check("R10", "flags_load", int'(flags_load), 1);
   endtask

   task automatic t_irq();
      int b = wr_cnt;
      pulse_req(1'b0, 1'b1);
      drive_bnd(3'd0, 16'h5000, 8'hC3, 16'h0000);
      wait_done();
      check("R5", "writes", wr_cnt - b, 3);
      check_wr("R5", b, 'h01FD, 'h50);
      check_wr("R5", b + 1, 'h01FC, 'h00);
      check_wr("R3", b + 2, 'h01FB, 'hE3);
      check("R5", "vector", int'(pc_out), 'h9000);
      check("R5", "entry flags", int'(flags_out), 'hE7);
   endtask

   task automatic t_irq_masked();
      int b = wr_cnt;
      pulse_req(1'b0, 1'b1);
      drive_bnd(3'd0, 16'h5555, 8'h04, 16'h0000);
      check("R7", "masked no busy", int'(busy), 0);
      drive_bnd(3'd0, 16'h5555, 8'h00, 16'h0000);
      check("R7", "dropped no busy", int'(busy), 0);
      check("R7", "no writes", wr_cnt - b, 0);
      check("R7", "sp unchanged", int'(sp_out), 'hFD);
   endtask

   task automatic t_nmi_prio();
      int b = wr_cnt;
      pulse_req(1'b1, 1'b1);
      drive_bnd(3'd2, 16'h6000, 8'h04, 16'h7777);
      wait_done();
      check("R6", "writes", wr_cnt - b, 3);
      check_wr("R6", b, 'h01FD, 'h60);
      check_wr("R6", b + 1, 'h01FC, 'h00);
      check_wr("R6", b + 2, 'h01FB, 'h24);
      check("R6", "nmi vector", int'(pc_out), 'hA000);
      b = wr_cnt;
      drive_bnd(3'd0, 16'h6000, 8'h00, 16'h0000);
      check("R7", "irq lost to nmi", int'(busy), 0);
      check("R7", "no writes", wr_cnt - b, 0);
      t_reti(8'h34, 16'h6000, 8'hFD);
   endtask

   task automatic t_busy_latch();
      int b = wr_cnt;
      @(negedge clk);
      boundary = 1'b1; op_sel = 3'd2; pc_in = 16'h2100; flags_in = 8'h04; call_target = 16'h2200;
      @(negedge clk);
      nmi_req = 1'b1; op_sel = 3'd3;
      @(negedge clk);
      nmi_req = 1'b0; boundary = 1'b0; op_sel = 3'd0;
      wait_done();
      check("R12", "call writes only", wr_cnt - b, 2);
      check("R12", "sp after call", int'(sp_out), 'hFB);
      check("R12", "pc_out call", int'(pc_out), 'h2200);
      @(negedge clk);
      check("R12", "no restart", int'(busy), 0);
      b = wr_cnt;
      drive_bnd(3'd3, 16'h2200, 8'h04, 16'h0000);
      wait_done();
      check("R12", "held nmi served", int'(pc_out), 'hA000);
      check("R6", "nmi beats op", wr_cnt - b, 3);
      check("R6", "sp after nmi", int'(sp_out), 'hF8);
      t_reti(8'h34, 16'h2200, 8'hFB);
      t_ret(16'h2103, 8'hFD, "R9");
   endtask

   task automatic t_pushf();
      int b = wr_cnt;
      drive_bnd(3'd5, 16'h1111, 8'h00, 16'h0000);
      wait_done();
      check("R11", "writes", wr_cnt - b, 1);
      check_wr("R11", b, 'h01FD, 'h30);
      check("R11", "pc_load absent", int'(pc_load), 0);
      check("R11", "flags_load absent", int'(flags_load), 0);
      check("R11", "sp", int'(sp_out), 'hFC);
   endtask

   task automatic t_wrap();
      int b;
      stk[8'hFD] = 8'h10; stk[8'hFE] = 8'h7F; stk[8'hFF] = 8'hFF; stk[8'h00] = 8'h12;
      t_ret(16'h7F11, 8'hFE, "R9");
      t_ret(16'h1300, 8'h00, "R2");
      b = wr_cnt;
      drive_bnd(3'd2, 16'h8000, 8'h00, 16'h8100);
      wait_done();
      check_wr("R2", b, 'h0100, 'h80);
      check_wr("R2", b + 1, 'h01FF, 'h02);
      check("R2", "sp wrap down", int'(sp_out), 'hFE);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL R13 watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      rst_n = 1'b0; boundary = 1'b0; op_sel = 3'd0; nmi_req = 1'b0; irq_req = 1'b0;
      pc_in = '0; flags_in = '0; call_target = '0;
      for (int i = 0; i < 256; i++) stk[i] = 8'h00;
      vecm[0] = 8'h00; vecm[1] = 8'hA0;
      vecm[2] = 8'h34; vecm[3] = 8'h12;
      vecm[4] = 8'h00; vecm[5] = 8'h90;
      repeat (3) @(negedge clk);
      check("R1", "busy in reset", int'(busy), 1);
      t_reset();
      t_call();
      t_ret(16'h2003, 8'hFD, "R9");
      t_brk();
      t_reti(8'h39, 16'h4002, 8'hFD);
      t_irq();
      t_reti(8'hF3, 16'h5000, 8'hFD);
      t_irq_masked();
      t_nmi_prio();
      t_busy_latch();
      t_pushf();
      t_wrap();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule